// File: doc/BRIEF.md
# Logical Clock Sampling and Delay Unit

This block derives one logical clock from two others, one step at a time. At each step where the step strobe is high, the trigger tick and the reference tick are each either present or absent. The block then decides, in the same step, whether the derived tick is present. The decision comes from a small amount of registered history, combined with the current inputs in combinational logic.

Four operations are provided, chosen by a 2-bit selector:

- **Strict sampling.** A trigger tick arms the unit. The next reference tick at a strictly later step produces the derived tick.
- **Loose sampling.** The same as strict sampling, except that a trigger and a reference tick in the same step also produce the derived tick.
- **Counted delay.** The derived tick fires on the N-th reference tick strictly after a trigger.
- **Preemption.** Trigger ticks pass through as derived ticks until the first reference tick. After that, the output stays silent until reset.

The selector is expected to stay constant between resets. All four operation machines run in parallel, and the selector picks which output reaches the port. Steps with the strobe low are empty: they change no state and never produce a tick.

Top module: `logical_tick_gen`

State machines:

- **Sampling machines** (one strict, one loose). States `SMP_IDLE` and `SMP_ARMED`.
  - Transition `arm`: a trigger tick without a reference tick.
  - Transition `fire`: a reference tick while armed, or in loose mode a trigger and reference tick together.
- **Delay machine.** States `DLY_IDLE` and `DLY_COUNT`, plus a phase counter from 0 to N-1.
  - Transition `start`: a trigger tick while idle.
  - Transition `advance`: a reference tick before the N-th.
  - Transition `expire`: the N-th reference tick, which produces the derived tick.
- **Preemption machine.** States `PRE_OPEN` and `PRE_SHUT`.
  - Transition `cut`: the first reference tick.

## Requirements
- R1: After reset every machine is idle, armed-free or open. The derived tick is low during reset. A lone reference tick right after reset produces no derived tick under strict sampling.
- R2: With op_sel=0 (strict), a reference tick produces the derived tick when a trigger tick occurred at a strictly earlier step and no reference tick occurred between that trigger and the current step.
- R3: Under strict sampling, a trigger tick in the same step as a reference tick neither fires nor arms for the following reference tick.
- R4: With op_sel=1 (loose), a trigger and reference tick in the same step produce the derived tick in that step.
- R5: Both sampling modes produce at most one derived tick per arming. The reference tick that produces the derived tick clears the pending state.
- R6: With op_sel=2 (delay), the derived tick occurs exactly at the N-th reference tick counted strictly after the starting trigger tick (N=3 by default). The machine then returns to idle.
- R7: Under delay, a reference tick in the same step as the starting trigger tick is not counted.
- R8: Under delay, trigger ticks that arrive while a count is running are ignored and do not restart it.
- R9: With op_sel=3 (preempt), the derived tick equals the trigger tick on every step before the first reference tick. At the step of the first reference tick, and on every later step, no derived tick occurs.
- R10: Steps with step_vld low produce no derived tick and leave every machine's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_vld | input | 1 | Marks a cycle as a logical step |
| tick_a | input | 1 | Trigger clock tick for this step |
| tick_b | input | 1 | Reference clock tick for this step |
| op_sel | input | 2 | 0 strict, 1 loose, 2 delay, 3 preempt |
| tick_out | output | 1 | Derived clock tick for this step |

## Verification
The assertions check the following on every cycle:

- the output is silent on empty steps;
- a sampled or delayed tick always coincides with a reference tick;
- a strict tick is always preceded by an earlier trigger;
- preemption only ever passes trigger ticks and stays silent for good once a reference tick has been seen.

Some properties can only be shown by the bench's scenarios, because they depend on exact occurrence counts:

- that the delay fires on precisely the N-th reference tick;
- that coincident ticks do or do not arm;
- that ticks arriving mid-count are ignored;
- that empty steps preserve pending state.

// File: rtl/lclk_pkg.sv
package lclk_pkg;

    typedef enum logic [1:0] {
        OP_STRICT  = 2'd0,
        OP_LOOSE   = 2'd1,
        OP_DELAY   = 2'd2,
        OP_PREEMPT = 2'd3
    } lclk_op_e;

    typedef enum logic {
        SMP_IDLE  = 1'b0,
        SMP_ARMED = 1'b1
    } smp_state_e;

    typedef enum logic {
        DLY_IDLE  = 1'b0,
        DLY_COUNT = 1'b1
    } dly_state_e;

    typedef enum logic {
        PRE_OPEN = 1'b0,
        PRE_SHUT = 1'b1
    } pre_state_e;

endpackage

// File: rtl/lclk_sampler.sv
module lclk_sampler #(
    parameter bit LOOSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_vld,
    input  logic tick_a,
    input  logic tick_b,
    output logic tick_out
);
    import lclk_pkg::*;

    smp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SMP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tick_out = 1'b0;
        if (step_vld) begin
            unique case (state_q)
                SMP_IDLE: begin
                    // In loose mode a coincident trigger and reference fire at once.
                    if (LOOSE && tick_a && tick_b) tick_out = 1'b1;
                    // arm: only a trigger without a reference tick arms.
                    if (tick_a && !tick_b) state_d = SMP_ARMED;
                end
                SMP_ARMED: begin
                    // fire: the reference tick consumes the arming.
                    if (tick_b) begin
                        tick_out = 1'b1;
                        state_d  = SMP_IDLE;
                    end
                end
                default: state_d = SMP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lclk_delay.sv
module lclk_delay #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_vld,
    input  logic tick_a,
    input  logic tick_b,
    output logic tick_out
);
    import lclk_pkg::*;

    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    dly_state_e    state_q, state_d;
    logic [CW-1:0] phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DLY_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        tick_out = 1'b0;
        if (step_vld) begin
            unique case (state_q)
                DLY_IDLE: begin
                    // start: a reference tick in this same step is not counted.
                    if (tick_a) begin
                        state_d = DLY_COUNT;
                        phase_d = '0;
                    end
                end
                DLY_COUNT: begin
                    // Trigger ticks are ignored while counting.
                    if (tick_b) begin
                        if (phase_q == LAST) begin
                            // expire
                            tick_out = 1'b1;
                            state_d  = DLY_IDLE;
                            phase_d  = '0;
                        end else begin
                            // advance
                            phase_d = phase_q + 1'b1;
                        end
                    end
                end
                default: state_d = DLY_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lclk_preempt.sv
module lclk_preempt (
    input  logic clk,
    input  logic rst_n,
    input  logic step_vld,
    input  logic tick_a,
    input  logic tick_b,
    output logic tick_out
);
    import lclk_pkg::*;

    pre_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PRE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tick_out = 1'b0;
        if (step_vld) begin
            unique case (state_q)
                PRE_OPEN: begin
                    if (tick_b) state_d = PRE_SHUT;  // cut
                    else        tick_out = tick_a;
                end
                PRE_SHUT: tick_out = 1'b0;
                default:  state_d = PRE_SHUT;
            endcase
        end
    end
endmodule

// File: rtl/logical_tick_gen.sv
module logical_tick_gen #(
    parameter int N = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_vld,
    input  logic       tick_a,
    input  logic       tick_b,
    input  logic [1:0] op_sel,
    output logic       tick_out
);
    import lclk_pkg::*;

    localparam int NOPS = 4;

    logic [NOPS-1:0] op_tick;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_smp
            lclk_sampler #(.LOOSE(g == 1)) u_smp (
                .clk(clk), .rst_n(rst_n), .step_vld(step_vld),
                .tick_a(tick_a), .tick_b(tick_b), .tick_out(op_tick[g])
            );
        end
    endgenerate

    lclk_delay #(.N(N)) u_dly (
        .clk(clk), .rst_n(rst_n), .step_vld(step_vld),
        .tick_a(tick_a), .tick_b(tick_b), .tick_out(op_tick[OP_DELAY])
    );

    lclk_preempt u_pre (
        .clk(clk), .rst_n(rst_n), .step_vld(step_vld),
        .tick_a(tick_a), .tick_b(tick_b), .tick_out(op_tick[OP_PREEMPT])
    );

    always_comb begin
        tick_out = rst_n & op_tick[op_sel];
    end
endmodule

// File: rtl/lclk_checker.sv
module lclk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       step_vld,
    input logic       tick_a,
    input logic       tick_b,
    input logic [1:0] op_sel,
    input logic       tick_out
);
    logic seen_a_q;
    logic seen_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else if (step_vld) begin
            seen_a_q <= seen_a_q | tick_a;
            seen_b_q <= seen_b_q | tick_b;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !tick_out);

    assert_empty_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_vld |-> !tick_out);

    assert_sample_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && op_sel[1] == 1'b0) |-> tick_b);

    assert_strict_prior_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && op_sel == 2'd0) |-> seen_a_q);

    assert_delay_on_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && op_sel == 2'd2) |-> (tick_b && seen_a_q));

    assert_preempt_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && op_sel == 2'd3) |-> (tick_a && !tick_b));

    assert_preempt_dead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'd3 && seen_b_q) |-> !tick_out);
endmodule

bind logical_tick_gen lclk_checker u_chk (
    .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .tick_a(tick_a),
    .tick_b(tick_b), .op_sel(op_sel), .tick_out(tick_out)
);

// File: tb/sim_logical_tick_gen.sv
module sim_logical_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_vld = 1'b0;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic       tick_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    logical_tick_gen #(.N(3)) u0 (
        .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .tick_a(tick_a),
        .tick_b(tick_b), .op_sel(op_sel), .tick_out(tick_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: tick_out=%0b expected %0b", req, got, exp);
        end
    endtask

    // Drive one cycle after a falling edge, sample before the next rising edge.
    task automatic step(input logic v, input logic a, input logic b,
                        input logic exp, input string req);
        @(negedge clk);
        step_vld = v; tick_a = a; tick_b = b;
        #2;
        check(tick_out, exp, req);
        @(posedge clk);
    endtask

    task automatic restart(input logic [1:0] op);
        @(negedge clk);
        rst_n = 1'b0; op_sel = op; step_vld = 1'b0; tick_a = 1'b0; tick_b = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #2;
        check(tick_out, 1'b0, "R1 during reset");
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        restart(2'd0);
        step(1, 0, 1, 0, "R1 ref after reset");
    endtask

    task automatic t_strict();
        restart(2'd0);
        step(1, 1, 0, 0, "R2 arm");
        step(1, 0, 0, 0, "R2 gap");
        step(1, 0, 1, 1, "R2 fire");
        step(1, 0, 1, 0, "R5 strict once");
        step(1, 1, 1, 0, "R3 coincident");
        step(1, 0, 1, 0, "R3 no arm");
        step(1, 1, 0, 0, "R2 rearm");
        step(1, 1, 1, 1, "R2 fire with trigger");
        step(1, 0, 1, 0, "R3 no rearm");
    endtask

    task automatic t_loose();
        restart(2'd1);
        step(1, 1, 1, 1, "R4 coincident");
        step(1, 0, 1, 0, "R5 loose once");
        step(1, 1, 0, 0, "R4 arm");
        step(1, 0, 1, 1, "R4 later ref");
    endtask

    task automatic t_delay();
        restart(2'd2);
        step(1, 1, 1, 0, "R7 start");
        step(1, 0, 1, 0, "R6 count1");
        step(1, 0, 1, 0, "R6 count2");
        step(1, 1, 0, 0, "R8 ignored trigger");
        step(1, 0, 1, 1, "R6 third ref");
        step(1, 0, 1, 0, "R6 idle after");
        step(1, 1, 0, 0, "R6 restart");
        step(1, 0, 1, 0, "R6 c1");
        step(1, 1, 1, 0, "R8 trigger with ref");
        step(1, 0, 1, 1, "R8 not restarted");
    endtask

    task automatic t_preempt();
        restart(2'd3);
        step(1, 1, 0, 1, "R9 pass1");
        step(1, 0, 0, 0, "R9 none");
        step(1, 1, 0, 1, "R9 pass2");
        step(1, 1, 1, 0, "R9 cut step");
        step(1, 1, 0, 0, "R9 after cut");
        step(1, 1, 0, 0, "R9 after cut 2");
    endtask

    task automatic t_valid();
        restart(2'd0);
        step(0, 1, 0, 0, "R10 empty trigger");
        step(1, 0, 1, 0, "R10 not armed");
        step(1, 1, 0, 0, "R10 arm");
        step(0, 0, 1, 0, "R10 empty ref");
        step(1, 0, 1, 1, "R10 state kept");
        restart(2'd3);
        step(0, 1, 0, 0, "R10 empty preempt");
        step(0, 0, 1, 0, "R10 empty cut");
        step(1, 1, 0, 1, "R10 still open");
    endtask

    initial begin
        t_reset();
        t_strict();
        t_loose();
        t_delay();
        t_preempt();
        t_valid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: tick_out=%0b expected completion", tick_out);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule